// File: doc/BRIEF.md
# Return-Address Hardware Stack

This block keeps the return addresses of a small microcontroller core in a fixed six-level last-in, first-out store. The core raises `pushCall` when it executes a subroutine call and `pushIrq` when it acknowledges an interrupt. On either strobe the block stores the program-counter value on `pcIn`. When the core executes a return or a return-from-interrupt it raises `pop`. The address it should jump back to is on `pcOut` in that cycle, and the level is released at the clock edge.

The block tells the interrupt controller whether an acknowledge may be taken. While all six levels are in use, `irqAckAllowed` is low. The interrupt stays pending in the controller until a return frees a level. A subroutine call on a full stack is not held off. It completes, and the oldest stored address is discarded, so the six most recent addresses remain. Neither the contents nor the level pointer can be reached through any data bus. The ports below are the whole interface.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the stack is empty: `full` is 0, `irqAckAllowed` is 1 and `pcOut` reads 0.
- R2: A push (`pushCall` or `pushIrq`) on a stack that is not full stores the 11-bit `pcIn` as the new top entry. From the next cycle `pcOut` shows that value and the depth has grown by one.
- R3: A `pop` on a non-empty stack releases the top entry. From the next cycle `pcOut` shows the entry that was pushed before it (last-in, first-out order).
- R4: `full` is 1 exactly when six entries are held, and the depth never goes beyond six.
- R5: `irqAckAllowed` is the inverse of `full`. A `pushIrq` alone on a full stack has no effect: the depth and `pcOut` stay the same.
- R6: A `pushCall` on a full stack completes. The new value becomes the top, the oldest entry is dropped, the other entries move down one level and the stack stays full.
- R7: A `pop` on an empty stack leaves the depth at zero. `pcOut` keeps showing the bottom entry (level 0) as last written.
- R8: A push and a `pop` in the same cycle are treated as a pop followed by a push. On a non-empty stack this replaces the top entry with `pcIn` and leaves the depth unchanged, including when the stack is full. On an empty stack it acts as a plain push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pushCall | input | 1 | Subroutine call: push `pcIn` |
| pushIrq | input | 1 | Interrupt acknowledge: push `pcIn` |
| pop | input | 1 | Return or return-from-interrupt: release the top entry |
| pcIn | input | 11 | Program-counter value to store |
| pcOut | output | 11 | Current top entry (bottom entry when empty) |
| full | output | 1 | All six levels in use |
| irqAckAllowed | output | 1 | Interrupt acknowledge may be taken |

## Verification
The hardest state to reach is a full stack that has been rotated by a call: the oldest address has been lost. A later run of returns must then unwind exactly the six surviving addresses, in order. The stimulus table first fills all six levels with distinct values, mixing calls and interrupt pushes. It tries a blocked interrupt push, frees one level, fills it again and issues one more call. It then pops until the stack is empty and past empty. This exposes which entry was dropped and what the bottom level holds afterwards. A directed sequence then fills the stack again and applies a simultaneous interrupt push and pop at full depth.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int RAS_DEPTH = 6;
  localparam int RAS_WIDTH = 11;
  localparam int RAS_IDX_W = $clog2(RAS_DEPTH + 1);

  typedef struct packed {
    logic                 wrEn;
    logic                 shiftEn;
    logic [RAS_IDX_W-1:0] wrIdx;
    logic [RAS_IDX_W-1:0] rdIdx;
  } rasStrobe_t;
endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = RAS_DEPTH,
  parameter int IDX_W = RAS_IDX_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pushCall,
  input  logic       pushIrq,
  input  logic       pop,
  output rasStrobe_t strobe,
  output logic       isFull
);
  localparam logic [IDX_W-1:0] FULL_LVL = IDX_W'(DEPTH);
  localparam logic [IDX_W-1:0] ONE      = IDX_W'(1);

  logic [IDX_W-1:0] ptr, ptrNext;
  logic isEmpty, popOk, pushOk;

  assign isFull  = (ptr == FULL_LVL);
  assign isEmpty = (ptr == '0);
  assign popOk   = pop & ~isEmpty;
  // an interrupt push is taken only if a level is free, or one is freed this cycle
  assign pushOk  = pushCall | (pushIrq & (~isFull | popOk));

  always_comb begin
    strobe.wrEn    = 1'b0;
    strobe.shiftEn = 1'b0;
    strobe.wrIdx   = ptr;
    strobe.rdIdx   = isEmpty ? '0 : ptr - ONE;
    ptrNext        = ptr;
    if (pushOk && popOk) begin
      strobe.wrEn  = 1'b1;
      strobe.wrIdx = ptr - ONE;
    end else if (pushOk && !isFull) begin
      strobe.wrEn  = 1'b1;
      strobe.wrIdx = ptr;
      ptrNext      = ptr + ONE;
    end else if (pushOk) begin
      strobe.shiftEn = 1'b1;
    end else if (popOk) begin
      ptrNext = ptr - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptrNext;
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= FULL_LVL);

  p_depth_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (ptr == $past(ptr)) || (ptr == $past(ptr) + ONE) || (ptr + ONE == $past(ptr)));

  p_irq_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (isFull && pushIrq && !pushCall && !pop) |=> (ptr == FULL_LVL));

  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (isEmpty && pop && !pushCall && !pushIrq) |=> (ptr == '0));

  p_swap_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!isEmpty && pop && pushCall) |=> $stable(ptr));

  p_call_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (isFull && pushCall && !pop) |=> (ptr == FULL_LVL));
endmodule

// File: rtl/ras_data.sv
module ras_data
  import ras_pkg::*;
#(
  parameter int DEPTH = RAS_DEPTH,
  parameter int WIDTH = RAS_WIDTH,
  parameter int IDX_W = RAS_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rasStrobe_t       strobe,
  input  logic [WIDTH-1:0] pcIn,
  output logic [WIDTH-1:0] pcOut
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_level
    if (i == DEPTH - 1) begin : g_top
      always_ff @(posedge clk) begin
        if (!rst_n) mem[i] <= '0;
        else if (strobe.shiftEn) mem[i] <= pcIn;
        else if (strobe.wrEn && strobe.wrIdx == IDX_W'(i)) mem[i] <= pcIn;
      end
    end else begin : g_lower
      always_ff @(posedge clk) begin
        if (!rst_n) mem[i] <= '0;
        else if (strobe.shiftEn) mem[i] <= mem[i+1];
        else if (strobe.wrEn && strobe.wrIdx == IDX_W'(i)) mem[i] <= pcIn;
      end
    end
  end

  assign pcOut = mem[strobe.rdIdx];

  p_shift_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.shiftEn |=> (mem[DEPTH-1] == $past(pcIn)));

  p_shift_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.shiftEn |=> (mem[0] == $past(mem[1])));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && !strobe.shiftEn) |=> (mem[$past(strobe.wrIdx)] == $past(pcIn)));
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int DEPTH = RAS_DEPTH,
  parameter int WIDTH = RAS_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pushCall,
  input  logic             pushIrq,
  input  logic             pop,
  input  logic [WIDTH-1:0] pcIn,
  output logic [WIDTH-1:0] pcOut,
  output logic             full,
  output logic             irqAckAllowed
);
  rasStrobe_t strobe;

  ras_ctrl #(.DEPTH(DEPTH), .IDX_W(RAS_IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pushCall(pushCall), .pushIrq(pushIrq),
    .pop(pop), .strobe(strobe), .isFull(full)
  );

  ras_data #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDX_W(RAS_IDX_W)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .pcIn(pcIn), .pcOut(pcOut)
  );

  assign irqAckAllowed = ~full;
endmodule

// File: tb/test_ret_addr_stack.sv
`timescale 1ns/1ps
module test_ret_addr_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pushCall = 1'b0, pushIrq = 1'b0, pop = 1'b0;
  logic [10:0] pcIn = '0;
  logic [10:0] pcOut;
  logic        full, irqAckAllowed;
  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  ret_addr_stack i_ret_addr_stack (
    .clk(clk), .rst_n(rst_n), .pushCall(pushCall), .pushIrq(pushIrq), .pop(pop),
    .pcIn(pcIn), .pcOut(pcOut), .full(full), .irqAckAllowed(irqAckAllowed)
  );

  // {call, irq, pop, pcIn[10:0], expPc[10:0], expFull, req[3:0]}
  localparam int NV = 22;
  localparam logic [29:0] VEC [NV] = '{
    {3'b100, 11'h101, 11'h101, 1'b0, 4'd2},  // R2 call
    {3'b010, 11'h202, 11'h202, 1'b0, 4'd2},  // R2 irq push
    {3'b100, 11'h303, 11'h303, 1'b0, 4'd2},
    {3'b100, 11'h404, 11'h404, 1'b0, 4'd2},
    {3'b100, 11'h505, 11'h505, 1'b0, 4'd2},
    {3'b010, 11'h606, 11'h606, 1'b1, 4'd4},  // R4 sixth entry -> full
    {3'b000, 11'h0F0, 11'h606, 1'b1, 4'd4},  // idle
    {3'b010, 11'h777, 11'h606, 1'b1, 4'd5},  // R5 irq on full ignored
    {3'b001, 11'h000, 11'h505, 1'b0, 4'd3},  // R3 pop
    {3'b010, 11'h7A7, 11'h7A7, 1'b1, 4'd5},  // R5 irq allowed again
    {3'b100, 11'h0AA, 11'h0AA, 1'b1, 4'd6},  // R6 call on full drops 101
    {3'b001, 11'h000, 11'h7A7, 1'b0, 4'd6},
    {3'b001, 11'h000, 11'h505, 1'b0, 4'd3},
    {3'b001, 11'h000, 11'h404, 1'b0, 4'd3},
    {3'b001, 11'h000, 11'h303, 1'b0, 4'd3},
    {3'b001, 11'h000, 11'h202, 1'b0, 4'd6},  // R6 bottom is 202, not 101
    {3'b001, 11'h000, 11'h202, 1'b0, 4'd7},  // now empty, bottom shown
    {3'b001, 11'h000, 11'h202, 1'b0, 4'd7},  // R7 pop on empty
    {3'b100, 11'h111, 11'h111, 1'b0, 4'd7},  // depth stayed 0: lands at level 0
    {3'b101, 11'h222, 11'h222, 1'b0, 4'd8},  // R8 swap top
    {3'b001, 11'h000, 11'h222, 1'b0, 4'd8},  // depth was 1 -> empty
    {3'b101, 11'h333, 11'h333, 1'b0, 4'd8}   // R8 swap on empty acts as push
  };

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic i, input logic p, input logic [10:0] v);
    pushCall = c; pushIrq = i; pop = p; pcIn = v;
    @(negedge clk);
    pushCall = 1'b0; pushIrq = 1'b0; pop = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pcOut", pcOut, 11'h000);
    check("R1 full", {10'd0, full}, 11'd0);
    check("R1 irqAckAllowed", {10'd0, irqAckAllowed}, 11'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [29:0] v;
      string tag;
      v = VEC[k];
      tag = $sformatf("R%0d vec%0d", v[3:0], k);
      drive(v[29], v[28], v[27], v[26:16]);
      check({tag, " pcOut"}, pcOut, v[15:5]);
      check({tag, " full"}, {10'd0, full}, {10'd0, v[4]});
      check({tag, " R5 ack"}, {10'd0, irqAckAllowed}, {10'd0, ~v[4]});
    end

    // R1: reset from a non-empty state
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 re-reset pcOut", pcOut, 11'h000);
    check("R1 re-reset full", {10'd0, full}, 11'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 at full depth with an interrupt push plus pop
    for (int k = 0; k < 6; k++) drive(1'b1, 1'b0, 1'b0, 11'(16 + k));
    check("R4 full after six", {10'd0, full}, 11'd1);
    drive(1'b0, 1'b1, 1'b1, 11'h7FF);
    check("R8 full swap pcOut", pcOut, 11'h7FF);
    check("R8 full swap full", {10'd0, full}, 11'd1);
    drive(1'b0, 1'b0, 1'b1, 11'h000);
    check("R3 after swap pop", pcOut, 11'h014);
    check("R5 ack after pop", {10'd0, irqAckAllowed}, 11'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule